// File: doc/BRIEF.md
# Banked CPU Register File with Aliased Views

This block holds the architectural registers of a small 16-bit processor core: four 16-bit data registers, eight 24-bit wide registers (two address registers, static base, frame base, program counter, interrupt table base, user stack pointer and interrupt stack pointer), a 16-bit flag word and a 16-bit flag shadow. The data registers can be reached as bytes (first two registers only), as words, or as two 32-bit pairs. Decode logic elsewhere in the core drives a single write port with a size code and a register id. It reads through separate combinational ports for the byte, word, pair and wide views.

Bit 7 of the flag word picks which of the two stack pointers is active. The active one appears on its own output and is the target of writes to the stack pointer alias id. A fast-interrupt save strobe copies the flag word into the shadow, and a restore strobe copies it back. A request whose size does not match its register id is dropped and flagged on a one-cycle error output.

Top module: `cpu_regfile`

## Requirements
- R1: Word writes (size code 1) to ids 0..3 load data registers D0..D3 from wr_data[15:0] at the rising edge. The read ports are combinational and show the value held before the edge during the cycle of a write.
- R2: Byte writes (size code 0) are legal only for ids 0 and 1. wr_hi=1 loads bits 15:8 and wr_hi=0 loads bits 7:0, both from wr_data[7:0], and the other byte stays unchanged. rd8_sel[1] picks D0 or D1 and rd8_sel[0]=1 picks the high byte.
- R3: Pair writes (size code 3) are legal for id 0, which is {D2,D0}, and id 1, which is {D3,D1}. Bits 31:16 go to the upper register and bits 15:0 to the lower one, both on the same edge. rd32_sel reads the pair with the same numbering.
- R4: Wide writes (size code 2) to ids 4..11 load wide registers W0..W7 (address 0, address 1, static base, frame base, program counter, table base, user stack, interrupt stack) from wr_data[23:0]. rd24_sel 0..7 reads W0..W7.
- R5: When flag bit 7 is 1, the user stack (W6) is active. When it is 0, the interrupt stack (W7) is active. sp_data shows the active one. A wide write to id 12 loads the stack pointer that was active before the edge.
- R6: fint_save copies the flag word into the shadow at the edge. It overrides a port write to the shadow in the same cycle.
- R7: fint_restore copies the shadow into the flag word and overrides a port write to the flag word. When fint_save and fint_restore are both asserted, the save happens and the restore is ignored.
- R8: Word writes to id 13 load the flag word and to id 14 load the shadow. Both are read on flg_data and svf_data.
- R9: Any other size and id pair is illegal: a byte write to ids 2..15, a word write to ids 4..12 or 15, a wide write to ids 0..3, 13, 14 or 15, or a pair write to ids 2..15. An illegal write changes no register, and err is 1 for exactly the cycle after it.
- R10: While rst_n is low at a rising edge, every register and err clear to zero, and the write port is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write request |
| wr_size | input | 2 | 0 byte, 1 word, 2 wide, 3 pair |
| wr_id | input | 4 | Target register id |
| wr_hi | input | 1 | Byte lane select for byte writes |
| wr_data | input | 32 | Write data |
| fint_save | input | 1 | Copy flag word into the shadow |
| fint_restore | input | 1 | Copy the shadow into the flag word |
| rd8_sel | input | 2 | Byte view select |
| rd8_data | output | 8 | Byte view data |
| rd16_sel | input | 2 | Word view select |
| rd16_data | output | 16 | Word view data |
| rd32_sel | input | 1 | Pair view select |
| rd32_data | output | 32 | Pair view data |
| rd24_sel | input | 3 | Wide register select |
| rd24_data | output | 24 | Wide register data |
| sp_data | output | 24 | Active stack pointer |
| flg_data | output | 16 | Flag word |
| svf_data | output | 16 | Flag shadow |
| err | output | 1 | Illegal request seen on the previous edge |

## Verification
Directed word, byte and pair writes to the same data registers show whether the lane enables keep the untouched byte and whether the two pair halves land in the right registers. Writes to the stack alias with flag bit 7 set and then cleared separate the two stack banks. Save and restore strobes, alone, together and combined with port writes to the flag word, settle each priority. Seeded random traffic, half of it steered to legal pairs and the rest unconstrained over size and id, mixes illegal requests in among legal ones. After every cycle all views are swept and compared against a bench model, and a read-before-write check runs during every write.

// File: rtl/cpu_rf_pkg.sv
`timescale 1ns/1ps
// Package: shared sizes, size codes and register ids for the register file.
// Assumes the data word is twice a byte and the pair view is two data words.
package cpu_rf_pkg;
    localparam int DATA_W = 16;
    localparam int HALF_W = DATA_W / 2;
    localparam int PAIR_W = 2 * DATA_W;
    localparam int ADDR_W = 24;
    localparam int FLAG_W = 16;
    localparam int N_DATA = 4;
    localparam int N_BYTE = 2;
    localparam int N_PAIR = 2;
    localparam int N_WIDE = 8;
    localparam int U_BIT  = 7;
    localparam int ID_W   = 4;
    localparam int DI_W   = $clog2(N_DATA);
    localparam int WI_W   = $clog2(N_WIDE);

    localparam logic [1:0] SZ_BYTE = 2'd0;
    localparam logic [1:0] SZ_WORD = 2'd1;
    localparam logic [1:0] SZ_WIDE = 2'd2;
    localparam logic [1:0] SZ_PAIR = 2'd3;

    localparam logic [ID_W-1:0] ID_W0  = ID_W'(4);
    localparam logic [ID_W-1:0] ID_SP  = ID_W'(4 + N_WIDE);
    localparam logic [ID_W-1:0] ID_FLG = ID_W'(13);
    localparam logic [ID_W-1:0] ID_SVF = ID_W'(14);

    localparam logic [WI_W-1:0] WI_USP = WI_W'(6);
    localparam logic [WI_W-1:0] WI_ISP = WI_W'(7);
endpackage

// File: rtl/rf_wr_decode.sv
`timescale 1ns/1ps
// Write decoder: turns (size, id, lane) into per-register lane enables and
// write values, and flags size/id pairs that are not defined.
// Assumes u_flag is the current (pre-edge) stack select bit.
module rf_wr_decode
    import cpu_rf_pkg::*;
(
    input  logic                           wr_en,
    input  logic [1:0]                     wr_size,
    input  logic [ID_W-1:0]                wr_id,
    input  logic                           wr_hi,
    input  logic [PAIR_W-1:0]              wr_data,
    input  logic                           u_flag,
    output logic [N_DATA-1:0]              d_lo_we,
    output logic [N_DATA-1:0]              d_hi_we,
    output logic [N_DATA-1:0][DATA_W-1:0]  d_wval,
    output logic [N_WIDE-1:0]              w_we,
    output logic [ADDR_W-1:0]              w_wval,
    output logic                           flg_we,
    output logic                           svf_we,
    output logic [FLAG_W-1:0]              f_wval,
    output logic                           illegal
);
    logic            legal;
    logic [WI_W-1:0] w_idx;
    logic [DI_W-1:0] d_idx;
    logic [DI_W-1:0] up_idx;

    // Decode the request into enables and values; mark undefined pairs.
    always_comb begin
        legal   = 1'b0;
        d_lo_we = '0;
        d_hi_we = '0;
        w_we    = '0;
        flg_we  = 1'b0;
        svf_we  = 1'b0;
        w_wval  = wr_data[ADDR_W-1:0];
        f_wval  = wr_data[FLAG_W-1:0];
        w_idx   = wr_id[WI_W-1:0] - ID_W0[WI_W-1:0];
        d_idx   = wr_id[DI_W-1:0];
        up_idx  = d_idx + DI_W'(N_PAIR);
        for (int i = 0; i < N_DATA; i++) begin
            d_wval[i] = wr_data[DATA_W-1:0];
        end
        case (wr_size)
            SZ_BYTE: begin
                if (wr_id < ID_W'(N_BYTE)) begin
                    legal = 1'b1;
                    d_wval[d_idx]  = {wr_data[HALF_W-1:0], wr_data[HALF_W-1:0]};
                    d_hi_we[d_idx] = wr_en & wr_hi;
                    d_lo_we[d_idx] = wr_en & ~wr_hi;
                end
            end
            SZ_WORD: begin
                if (wr_id < ID_W'(N_DATA)) begin
                    legal = 1'b1;
                    d_hi_we[d_idx] = wr_en;
                    d_lo_we[d_idx] = wr_en;
                end else if (wr_id == ID_FLG) begin
                    legal  = 1'b1;
                    flg_we = wr_en;
                end else if (wr_id == ID_SVF) begin
                    legal  = 1'b1;
                    svf_we = wr_en;
                end
            end
            SZ_WIDE: begin
                if (wr_id >= ID_W0 && wr_id < ID_SP) begin
                    legal = 1'b1;
                    w_we[w_idx] = wr_en;
                end else if (wr_id == ID_SP) begin
                    legal = 1'b1;
                    w_we[u_flag ? WI_USP : WI_ISP] = wr_en;
                end
            end
            default: begin
                if (wr_id < ID_W'(N_PAIR)) begin
                    legal = 1'b1;
                    d_hi_we[d_idx]  = wr_en;
                    d_lo_we[d_idx]  = wr_en;
                    d_hi_we[up_idx] = wr_en;
                    d_lo_we[up_idx] = wr_en;
                    d_wval[up_idx]  = wr_data[PAIR_W-1:DATA_W];
                end
            end
        endcase
        illegal = wr_en & ~legal;
    end
endmodule

// File: rtl/rf_data_bank.sv
`timescale 1ns/1ps
// Data bank: N_DATA word registers, each with separate low and high byte
// write enables so byte, word and pair views share one storage.
// Assumes enables are already qualified by the decoder.
module rf_data_bank
    import cpu_rf_pkg::*;
(
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [N_DATA-1:0]              lo_we,
    input  logic [N_DATA-1:0]              hi_we,
    input  logic [N_DATA-1:0][DATA_W-1:0]  wval,
    output logic [N_DATA-1:0][DATA_W-1:0]  q
);
    for (genvar g = 0; g < N_DATA; g++) begin : g_word
        logic [DATA_W-1:0] r;
        // Hold one data word; each byte lane loads on its own enable.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                r <= '0;
            end else begin
                if (lo_we[g]) r[HALF_W-1:0]      <= wval[g][HALF_W-1:0];
                if (hi_we[g]) r[DATA_W-1:HALF_W] <= wval[g][DATA_W-1:HALF_W];
            end
        end
        assign q[g] = r;
    end
endmodule

// File: rtl/rf_wide_bank.sv
`timescale 1ns/1ps
// Wide bank: N_WIDE address-width registers with one shared write value.
// Assumes at most one enable is high per cycle.
module rf_wide_bank
    import cpu_rf_pkg::*;
(
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [N_WIDE-1:0]              we,
    input  logic [ADDR_W-1:0]              wval,
    output logic [N_WIDE-1:0][ADDR_W-1:0]  q
);
    for (genvar g = 0; g < N_WIDE; g++) begin : g_wide
        logic [ADDR_W-1:0] r;
        // Hold one wide register, loaded on its enable.
        always_ff @(posedge clk) begin
            if (!rst_n)     r <= '0;
            else if (we[g]) r <= wval;
        end
        assign q[g] = r;
    end
endmodule

// File: rtl/rf_flag_unit.sv
`timescale 1ns/1ps
// Flag unit: flag word and its shadow, with save/restore strobes that take
// precedence over port writes; save beats restore when both are high.
// Assumes strobes are single-cycle requests from the interrupt logic.
module rf_flag_unit
    import cpu_rf_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flg_we,
    input  logic              svf_we,
    input  logic [FLAG_W-1:0] f_wval,
    input  logic              save,
    input  logic              restore,
    output logic [FLAG_W-1:0] flg_q,
    output logic [FLAG_W-1:0] svf_q,
    output logic              u_flag
);
    logic do_restore;
    assign do_restore = restore & ~save;

    // Flag word: restore from shadow, else port write.
    always_ff @(posedge clk) begin
        if (!rst_n)          flg_q <= '0;
        else if (do_restore) flg_q <= svf_q;
        else if (flg_we)     flg_q <= f_wval;
    end

    // Shadow: snapshot on save, else port write.
    always_ff @(posedge clk) begin
        if (!rst_n)      svf_q <= '0;
        else if (save)   svf_q <= flg_q;
        else if (svf_we) svf_q <= f_wval;
    end

    assign u_flag = flg_q[U_BIT];
endmodule

// File: rtl/cpu_regfile.sv
`timescale 1ns/1ps
// Top: banked register file with byte/word/pair views of the data registers,
// wide registers with a flag-selected stack pointer, a flag shadow and a
// one-cycle error pulse for undefined requests.
// Assumes reads are combinational and all state changes on the rising edge.
module cpu_regfile
    import cpu_rf_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_size,
    input  logic [ID_W-1:0]   wr_id,
    input  logic              wr_hi,
    input  logic [PAIR_W-1:0] wr_data,
    input  logic              fint_save,
    input  logic              fint_restore,
    input  logic [1:0]        rd8_sel,
    output logic [HALF_W-1:0] rd8_data,
    input  logic [DI_W-1:0]   rd16_sel,
    output logic [DATA_W-1:0] rd16_data,
    input  logic              rd32_sel,
    output logic [PAIR_W-1:0] rd32_data,
    input  logic [WI_W-1:0]   rd24_sel,
    output logic [ADDR_W-1:0] rd24_data,
    output logic [ADDR_W-1:0] sp_data,
    output logic [FLAG_W-1:0] flg_data,
    output logic [FLAG_W-1:0] svf_data,
    output logic              err
);
    logic [N_DATA-1:0]              d_lo_we, d_hi_we;
    logic [N_DATA-1:0][DATA_W-1:0]  d_wval, d_regs;
    logic [N_WIDE-1:0]              w_we;
    logic [ADDR_W-1:0]              w_wval;
    logic [N_WIDE-1:0][ADDR_W-1:0]  w_regs;
    logic                           flg_we, svf_we, illegal, u_flag;
    logic [FLAG_W-1:0]              f_wval, flg_q, svf_q;
    logic [DATA_W-1:0]              byte_src;

    rf_wr_decode u_dec (
        .wr_en   (wr_en),
        .wr_size (wr_size),
        .wr_id   (wr_id),
        .wr_hi   (wr_hi),
        .wr_data (wr_data),
        .u_flag  (u_flag),
        .d_lo_we (d_lo_we),
        .d_hi_we (d_hi_we),
        .d_wval  (d_wval),
        .w_we    (w_we),
        .w_wval  (w_wval),
        .flg_we  (flg_we),
        .svf_we  (svf_we),
        .f_wval  (f_wval),
        .illegal (illegal)
    );

    rf_data_bank u_data (
        .clk   (clk),
        .rst_n (rst_n),
        .lo_we (d_lo_we),
        .hi_we (d_hi_we),
        .wval  (d_wval),
        .q     (d_regs)
    );

    rf_wide_bank u_wide (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (w_we),
        .wval  (w_wval),
        .q     (w_regs)
    );

    rf_flag_unit u_flag_unit (
        .clk     (clk),
        .rst_n   (rst_n),
        .flg_we  (flg_we),
        .svf_we  (svf_we),
        .f_wval  (f_wval),
        .save    (fint_save),
        .restore (fint_restore),
        .flg_q   (flg_q),
        .svf_q   (svf_q),
        .u_flag  (u_flag)
    );

    // Register the illegal-request indication as a one-cycle pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) err <= 1'b0;
        else        err <= illegal;
    end

    // Combinational read views over the shared storage.
    always_comb begin
        byte_src  = d_regs[{1'b0, rd8_sel[1]}];
        rd8_data  = rd8_sel[0] ? byte_src[DATA_W-1:HALF_W] : byte_src[HALF_W-1:0];
        rd16_data = d_regs[rd16_sel];
        rd32_data = {d_regs[{1'b1, rd32_sel}], d_regs[{1'b0, rd32_sel}]};
        rd24_data = w_regs[rd24_sel];
        sp_data   = u_flag ? w_regs[WI_USP] : w_regs[WI_ISP];
        flg_data  = flg_q;
        svf_data  = svf_q;
    end
endmodule

// File: rtl/cpu_regfile_chk.sv
`timescale 1ns/1ps
// Checker: temporal properties of the register file, bound to the top.
// Assumes it sees the top's data storage and flag registers by name.
module cpu_regfile_chk
    import cpu_rf_pkg::*;
(
    input logic                          clk,
    input logic                          rst_n,
    input logic                          wr_en,
    input logic [1:0]                    wr_size,
    input logic [ID_W-1:0]               wr_id,
    input logic                          wr_hi,
    input logic [PAIR_W-1:0]             wr_data,
    input logic                          fint_save,
    input logic                          fint_restore,
    input logic                          err,
    input logic [N_DATA-1:0][DATA_W-1:0] d_regs,
    input logic [FLAG_W-1:0]             flg_q,
    input logic [FLAG_W-1:0]             svf_q
);
    // R9
    byte_upper_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_size == SZ_BYTE && (wr_id == 4'd2 || wr_id == 4'd3)) |=> err);

    // R9
    bad_pair_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_size == SZ_PAIR && wr_id > 4'd1) |=> (d_regs == $past(d_regs)));

    // R9
    err_idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> !err);

    // R2
    byte_lo_keep_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_size == SZ_BYTE && wr_id == 4'd0 && !wr_hi)
        |=> (d_regs[0][DATA_W-1:HALF_W] == $past(d_regs[0][DATA_W-1:HALF_W])
             && d_regs[0][HALF_W-1:0] == $past(wr_data[HALF_W-1:0])));

    // R3
    pair_one_split_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_size == SZ_PAIR && wr_id == 4'd1)
        |=> ({d_regs[3], d_regs[1]} == $past(wr_data)));

    // R6
    save_snapshot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fint_save |=> (svf_q == $past(flg_q)));

    // R7
    restore_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fint_restore && !fint_save) |=> (flg_q == $past(svf_q)));

    // R7
    save_beats_restore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fint_save && fint_restore && !wr_en) |=> (flg_q == $past(flg_q)));
endmodule

bind cpu_regfile cpu_regfile_chk u_chk (.*);

// File: tb/tb_cpu_regfile.sv
`timescale 1ns/1ps
// Bench: directed corners plus seeded random traffic, checked against a
// behavioural model of every register after each cycle.
module tb_cpu_regfile;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        wr_en, wr_hi, fint_save, fint_restore, rd32_sel;
    logic [1:0]  wr_size, rd8_sel, rd16_sel;
    logic [3:0]  wr_id;
    logic [31:0] wr_data;
    logic [2:0]  rd24_sel;
    logic [7:0]  rd8_data;
    logic [15:0] rd16_data, flg_data, svf_data;
    logic [31:0] rd32_data;
    logic [23:0] rd24_data, sp_data;
    logic        err;

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    logic [15:0] m_d [4];
    logic [23:0] m_w [8];
    logic [15:0] m_flg, m_svf;
    logic        m_err;

    cpu_regfile dut (.*);

    always #5 clk = ~clk;

    task automatic chk(input logic [31:0] act, input logic [31:0] exp,
                       input string ctx, input string tag);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s [%s]: got %h expected %h", tag, ctx, act, exp);
        end
    endtask

    function automatic bit legal_f(input logic [1:0] s, input logic [3:0] id);
        case (s)
            2'd0:    return id < 4'd2;
            2'd1:    return id < 4'd4 || id == 4'd13 || id == 4'd14;
            2'd2:    return id >= 4'd4 && id <= 4'd12;
            default: return id < 4'd2;
        endcase
    endfunction

    // Model of one rising edge using the inputs currently driven.
    task automatic model_edge();
        logic [15:0] of, os, nf, ns;
        of = m_flg; os = m_svf; nf = of; ns = os;
        if (wr_en && legal_f(wr_size, wr_id)) begin
            case (wr_size)
                2'd0: if (wr_hi) m_d[wr_id[1:0]][15:8] = wr_data[7:0];
                      else       m_d[wr_id[1:0]][7:0]  = wr_data[7:0];
                2'd1: begin
                    if (wr_id < 4'd4)       m_d[wr_id[1:0]] = wr_data[15:0];
                    else if (wr_id == 4'd13) nf = wr_data[15:0];
                    else                     ns = wr_data[15:0];
                end
                2'd2: if (wr_id == 4'd12) m_w[of[7] ? 6 : 7] = wr_data[23:0];
                      else               m_w[wr_id - 4'd4] = wr_data[23:0];
                default: begin
                    m_d[wr_id[1:0]]        = wr_data[15:0];
                    m_d[wr_id[1:0] + 2'd2] = wr_data[31:16];
                end
            endcase
        end
        if (fint_save) ns = of;
        else if (fint_restore) nf = os;
        m_flg = nf; m_svf = ns;
        m_err = wr_en && !legal_f(wr_size, wr_id);
    endtask

    // Sweep every read view and compare with the model.
    task automatic check_all(input string ctx);
        logic [15:0] src;
        chk(32'(err), 32'(m_err), ctx, "R9 err");
        chk(32'(flg_data), 32'(m_flg), ctx, "R8 flag");
        chk(32'(svf_data), 32'(m_svf), ctx, "R6 shadow");
        chk(32'(sp_data), 32'(m_flg[7] ? m_w[6] : m_w[7]), ctx, "R5 active sp");
        for (int k = 0; k < 8; k++) begin
            rd24_sel = 3'(k); rd8_sel = 2'(k); rd16_sel = 2'(k); rd32_sel = k[0];
            #0.4;
            chk(32'(rd24_data), 32'(m_w[k]), ctx, "R4 wide");
            if (k < 4) begin
                src = m_d[k >> 1];
                chk(32'(rd8_data), 32'(k[0] ? src[15:8] : src[7:0]), ctx, "R2 byte");
                chk(32'(rd16_data), 32'(m_d[k]), ctx, "R1 word");
            end
            if (k < 2) chk(rd32_data, {m_d[k + 2], m_d[k]}, ctx, "R3 pair");
        end
    endtask

    // One cycle of stimulus, started at a falling edge.
    task automatic apply(input logic en, input logic [1:0] s, input logic [3:0] id,
                         input logic hi, input logic [31:0] d,
                         input logic sv, input logic rs, input string ctx);
        wr_en = en; wr_size = s; wr_id = id; wr_hi = hi; wr_data = d;
        fint_save = sv; fint_restore = rs; rd16_sel = id[1:0];
        #1;
        chk(32'(rd16_data), 32'(m_d[id[1:0]]), ctx, "R1 read-before-write");
        @(posedge clk);
        model_edge();
        @(negedge clk);
        wr_en = 1'b0; fint_save = 1'b0; fint_restore = 1'b0;
        check_all(ctx);
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog (R1..all): got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        logic [1:0]  s;
        logic [3:0]  id;
        void'($urandom(32'd4711));
        for (int i = 0; i < 4; i++) m_d[i] = '0;
        for (int i = 0; i < 8; i++) m_w[i] = '0;
        m_flg = '0; m_svf = '0; m_err = 1'b0;
        rst_n = 1'b0;
        wr_en = 1'b1; wr_size = 2'd1; wr_id = 4'd0; wr_hi = 1'b0;
        wr_data = 32'hFFFF_FFFF; fint_save = 1'b0; fint_restore = 1'b0;
        rd8_sel = '0; rd16_sel = '0; rd32_sel = 1'b0; rd24_sel = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1; wr_en = 1'b0;
        check_all("R10 reset state, write during reset ignored");

        // R1 words
        apply(1, 2'd1, 4'd0, 0, 32'h0000_1234, 0, 0, "R1 word D0");
        apply(1, 2'd1, 4'd1, 0, 32'h0000_ABCD, 0, 0, "R1 word D1");
        apply(1, 2'd1, 4'd2, 0, 32'h0000_5555, 0, 0, "R1 word D2");
        apply(1, 2'd1, 4'd3, 0, 32'h0000_AAAA, 0, 0, "R1 word D3");
        // R2 bytes
        apply(1, 2'd0, 4'd0, 1, 32'hFFFF_FF5A, 0, 0, "R2 byte D0 high");
        apply(1, 2'd0, 4'd1, 0, 32'hFFFF_FF77, 0, 0, "R2 byte D1 low");
        // R3 pairs
        apply(1, 2'd3, 4'd0, 0, 32'hDEAD_BEEF, 0, 0, "R3 pair 0");
        apply(1, 2'd3, 4'd1, 0, 32'h0123_4567, 0, 0, "R3 pair 1");
        // R4 wide
        for (int k = 4; k < 12; k++)
            apply(1, 2'd2, 4'(k), 0, 32'hAB00_0000 | 32'(k * 32'h0101_01), 0, 0, "R4 wide");
        // R5 stack select
        apply(1, 2'd1, 4'd13, 0, 32'h0000_0080, 0, 0, "R8 flag U=1");
        apply(1, 2'd2, 4'd12, 0, 32'h0011_1111, 0, 0, "R5 sp write user");
        apply(1, 2'd1, 4'd13, 0, 32'h0000_0000, 0, 0, "R8 flag U=0");
        apply(1, 2'd2, 4'd12, 0, 32'h0022_2222, 0, 0, "R5 sp write interrupt");
        // R9 illegal
        apply(1, 2'd0, 4'd2, 1, 32'h0000_00EE, 0, 0, "R9 byte to D2");
        apply(1, 2'd3, 4'd5, 0, 32'hCAFE_F00D, 0, 0, "R9 pair id5");
        apply(1, 2'd1, 4'd4, 0, 32'h0000_9999, 0, 0, "R9 word id4");
        apply(1, 2'd2, 4'd3, 0, 32'h0033_3333, 0, 0, "R9 wide id3");
        apply(1, 2'd2, 4'd15, 0, 32'h0044_4444, 0, 0, "R9 id15");
        apply(0, 2'd0, 4'd2, 0, 32'h0, 0, 0, "R9 err clears");
        // R6 / R7 strobes
        apply(1, 2'd1, 4'd13, 0, 32'h0000_00A5, 0, 0, "R8 flag load");
        apply(0, 2'd0, 4'd0, 0, 32'h0, 1, 0, "R6 save");
        apply(1, 2'd1, 4'd13, 0, 32'h0000_0F0F, 0, 0, "R8 flag change");
        apply(1, 2'd1, 4'd13, 0, 32'h0000_1111, 0, 1, "R7 restore beats flag write");
        apply(1, 2'd1, 4'd13, 0, 32'h0000_3333, 0, 0, "R8 flag change");
        apply(0, 2'd0, 4'd0, 0, 32'h0, 1, 1, "R7 save and restore together");
        apply(1, 2'd1, 4'd13, 0, 32'h0000_4444, 1, 0, "R6 save with flag write");
        apply(1, 2'd1, 4'd14, 0, 32'h0000_7777, 1, 0, "R6 save beats shadow write");
        apply(1, 2'd1, 4'd14, 0, 32'h0000_5A5A, 0, 0, "R8 shadow write");

        // Seeded random traffic
        for (int n = 0; n < 3000; n++) begin
            s = 2'($urandom % 4);
            if ($urandom % 2 == 0) begin
                case (s)
                    2'd1: begin
                        id = 4'($urandom % 6);
                        if (id == 4'd4) id = 4'd13;
                        if (id == 4'd5) id = 4'd14;
                    end
                    2'd2:    id = 4'(4 + $urandom % 9);
                    default: id = 4'($urandom % 2);
                endcase
            end else begin
                id = 4'($urandom % 16);
            end
            apply(($urandom % 8) != 0, s, id, 1'($urandom % 2), $urandom,
                  ($urandom % 10) == 0, ($urandom % 10) == 0, "random");
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule